// File: doc/BRIEF.md
# Pixel Chip Control Sequencer

This block sits between a command decoder and one pixel readout chip. It drives the chip's control pins: two mode bits, the shutter, the enable input, an active-low reset and a one-cycle transfer-start strobe. It receives a decoded operation code and steps through one of five chip operations: load the pixel matrix, read the pixel matrix, load the DACs, count with the shutter open, or clear the matrix. For each operation it first presents the mode bits, lets them settle, and then performs the operation.

Transfers end when the chip raises its enable-out return line. If that line stays low past a programmable timeout, the sequencer enters an error state and raises an error flag. Only an explicit clear command leaves that state. Shutter timing comes either from a programmed cycle count or from an external shutter input.

A bank of sixteen 16-bit registers is written and read through a simple synchronous port. Three of its addresses also set the sequencer's operation: shutter length, transfer timeout and shutter source.

Top module: `pixchip_seq`

## Requirements
- R1: During and right after reset (synchronous, active high): chip_mode = 00, chip_shutter = 0, chip_enable_in = 0, chip_reset_n = 1, xfer_start = 0, err_flag = 0.
- R2: Operation codes on cmd_op: 0 clear matrix, 1 load matrix, 2 read matrix, 3 load DACs, 4 count, 5 clear error. For codes 0 to 3 the mode bits take chip_mode = code[1:0] (00 clear, 01 load, 10 read, 11 DACs) two cycles after the cycle in which cmd_valid is sampled. They stay unchanged for two full cycles before chip_enable_in rises or chip_reset_n falls, which happens four cycles after the command edge.
- R3: For codes 1 to 3, chip_enable_in stays high and xfer_start pulses for exactly the first cycle of it. chip_enable_in drops one cycle after chip_enable_out is sampled high in a transfer cycle, and the sequencer returns to idle.
- R4: Register address 1 holds the transfer timeout T (0 acts as 1). If chip_enable_out is not seen within T transfer cycles, chip_enable_in drops and err_flag rises together, T cycles after chip_enable_in rose.
- R5: While err_flag is set, every command except code 5 is ignored and err_flag stays set. Code 5 clears err_flag one cycle after its command edge.
- R6: Code 0 drives chip_reset_n low for exactly 16 cycles, then returns to idle.
- R7: With register address 2 bit 0 = 0, code 4 opens chip_shutter two cycles after the command edge for exactly N cycles, where N is register address 0 (0 acts as 1).
- R8: With register address 2 bit 0 = 1, code 4 makes chip_shutter follow ext_shutter one cycle late. The count ends one cycle after ext_shutter falls, having first been high during the count.
- R9: Commands while busy, codes 6 and 7, chip_enable_out outside a transfer and ext_shutter outside an external-source count have no effect. At most one of enable-in high, reset low and shutter open holds at any time.
- R10: A register written at an address reads back at reg_rdata one cycle after the read address is presented. All sixteen addresses are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| ext_shutter | input | 1 | External shutter source |
| chip_enable_out | input | 1 | Completion return from the chip |
| chip_mode | output | 2 | Chip mode bits {M1,M0} |
| chip_shutter | output | 1 | Shutter, high = open |
| chip_enable_in | output | 1 | Chip enable input, high = active |
| chip_reset_n | output | 1 | Chip matrix reset, active low |
| xfer_start | output | 1 | One-cycle strobe at the start of a transfer |
| err_flag | output | 1 | Timeout error status |

## Verification
The embedded properties check, on every cycle, the structural rules of the chip interface. Mode bits hold still through the settle window before enable-in rises. The start strobe coincides with the rising edge of enable-in. Enable-in, reset-low and shutter-open never overlap. The error flag persists until a clear command and keeps the chip pins quiet. Every reset-low pulse lasts exactly the hold length. What the properties cannot show is the timing that depends on register contents and external stimulus. The bench's scenarios cover that: exact latencies from command to pin, the timeout taken from the bank, shutter duration with zero and non-zero lengths, one-cycle tracking of the external shutter, register readback, and the absence of any pin activity after ignored stimulus.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int DATA_W = 16;
  localparam int REG_N  = 16;
  localparam int ADDR_W = $clog2(REG_N);

  typedef enum logic [3:0] {
    ST_ERROR, ST_IDLE, ST_DECODE, ST_MODE, ST_SETPIX,
    ST_READPIX, ST_SETDAC, ST_COUNT, ST_CLRPIX
  } seq_state_e;

  localparam logic [2:0] OP_CLRPIX  = 3'd0;
  localparam logic [2:0] OP_SETPIX  = 3'd1;
  localparam logic [2:0] OP_READPIX = 3'd2;
  localparam logic [2:0] OP_SETDAC  = 3'd3;
  localparam logic [2:0] OP_COUNT   = 3'd4;
  localparam logic [2:0] OP_CLRERR  = 3'd5;

  localparam int CFG_SHUT = 0;
  localparam int CFG_TMO  = 1;
  localparam int CFG_EXT  = 2;
endpackage

// File: rtl/pxs_regbank.sv
module pxs_regbank
  import pxs_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int N       = REG_N,
  parameter int LEN_RST = 1,
  parameter int TMO_RST = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [DW-1:0]        shut_len,
  output logic [DW-1:0]        tmo_len,
  output logic                 ext_mode
);
  localparam int AW = $clog2(N);

  logic [DW-1:0] mem [N];

  // plain storage: no reset, registered read, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  // shadow copies of the configuration words for the sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      shut_len <= DW'(LEN_RST);
      tmo_len  <= DW'(TMO_RST);
      ext_mode <= 1'b0;
    end else if (we) begin
      if (addr == AW'(CFG_SHUT)) shut_len <= wdata;
      if (addr == AW'(CFG_TMO))  tmo_len  <= wdata;
      if (addr == AW'(CFG_EXT))  ext_mode <= wdata[0];
    end
  end
endmodule

// File: rtl/pxs_fsm.sv
module pxs_fsm
  import pxs_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int SETTLE   = 2,
  parameter int RST_HOLD = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] shut_len,
  input  logic [DW-1:0] tmo_len,
  input  logic          ext_mode,
  input  logic          ext_shutter,
  input  logic          enable_out,
  output logic [1:0]    mode,
  output logic          shutter,
  output logic          enable_in,
  output logic          reset_n,
  output logic          xfer_start,
  output logic          err_flag
);
  localparam int HW = $clog2(RST_HOLD) + 2;

  seq_state_e    state_q, state_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [2:0]    op_q, op_d;
  logic          seen_q, seen_d;
  logic          last_cnt, last_tmo;

  function automatic logic is_xfer(seq_state_e s);
    return (s == ST_SETPIX) || (s == ST_READPIX) || (s == ST_SETDAC);
  endfunction

  assign last_cnt = ({1'b0, cnt_q} + 1'b1) >= {1'b0, shut_len};
  assign last_tmo = ({1'b0, cnt_q} + 1'b1) >= {1'b0, tmo_len};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    seen_d  = seen_q;
    case (state_q)
      ST_IDLE: if (cmd_valid) begin
        op_d    = cmd_op;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        cnt_d  = '0;
        seen_d = 1'b0;
        if (op_q <= OP_SETDAC)     state_d = ST_MODE;
        else if (op_q == OP_COUNT) state_d = ST_COUNT;
        else                       state_d = ST_IDLE;
      end
      ST_MODE: begin
        if (cnt_q == DW'(SETTLE - 1)) begin
          cnt_d = '0;
          case (op_q[1:0])
            2'd0:    state_d = ST_CLRPIX;
            2'd1:    state_d = ST_SETPIX;
            2'd2:    state_d = ST_READPIX;
            default: state_d = ST_SETDAC;
          endcase
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SETPIX, ST_READPIX, ST_SETDAC: begin
        if (enable_out)    state_d = ST_IDLE;
        else if (last_tmo) state_d = ST_ERROR;
        else               cnt_d = cnt_q + 1'b1;
      end
      ST_CLRPIX: begin
        if (cnt_q == DW'(RST_HOLD - 1)) state_d = ST_IDLE;
        else                           cnt_d = cnt_q + 1'b1;
      end
      ST_COUNT: begin
        if (ext_mode) begin
          if (ext_shutter) seen_d = 1'b1;
          else if (seen_q) state_d = ST_IDLE;
        end else begin
          if (last_cnt) state_d = ST_IDLE;
          else          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ERROR: if (cmd_valid && cmd_op == OP_CLRERR) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // outputs registered from the next state so pins align with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      op_q       <= '0;
      seen_q     <= 1'b0;
      mode       <= 2'b00;
      shutter    <= 1'b0;
      enable_in  <= 1'b0;
      reset_n    <= 1'b1;
      xfer_start <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      op_q       <= op_d;
      seen_q     <= seen_d;
      if (state_q == ST_DECODE && state_d == ST_MODE) mode <= op_q[1:0];
      shutter    <= (state_d == ST_COUNT) && (ext_mode ? ext_shutter : 1'b1);
      enable_in  <= is_xfer(state_d);
      reset_n    <= (state_d != ST_CLRPIX);
      xfer_start <= (state_q == ST_MODE) && is_xfer(state_d);
      err_flag   <= (state_d == ST_ERROR);
    end
  end

  // checker-side run length of the reset-low pulse
  logic [HW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || reset_n) low_run <= '0;
    else                low_run <= low_run + 1'b1;
  end

  AST_MODE_SETTLED: assert property (@(posedge clk) disable iff (rst)
    ($rose(enable_in) || $fell(reset_n)) |-> ($stable(mode) && $past(mode, 1) == $past(mode, 2))); // R2
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (enable_in && !$past(enable_in))); // R3
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (!enable_in && reset_n && !shutter)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !(cmd_valid && cmd_op == OP_CLRERR)) |=> err_flag); // R5
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_n) |-> (low_run == HW'(RST_HOLD))); // R6
  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
    $countones({enable_in, !reset_n, shutter}) <= 1); // R9
endmodule

// File: rtl/pixchip_seq.sv
module pixchip_seq
  import pxs_pkg::*;
#(
  parameter int SETTLE   = 2,
  parameter int RST_HOLD = 16,
  parameter int LEN_RST  = 1,
  parameter int TMO_RST  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_shutter,
  input  logic              chip_enable_out,
  output logic [1:0]        chip_mode,
  output logic              chip_shutter,
  output logic              chip_enable_in,
  output logic              chip_reset_n,
  output logic              xfer_start,
  output logic              err_flag
);
  logic [DATA_W-1:0] shut_len, tmo_len;
  logic              ext_mode;

  pxs_regbank #(.DW(DATA_W), .N(REG_N), .LEN_RST(LEN_RST), .TMO_RST(TMO_RST)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .shut_len(shut_len), .tmo_len(tmo_len), .ext_mode(ext_mode)
  );

  pxs_fsm #(.DW(DATA_W), .SETTLE(SETTLE), .RST_HOLD(RST_HOLD)) u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .shut_len(shut_len), .tmo_len(tmo_len), .ext_mode(ext_mode),
    .ext_shutter(ext_shutter), .enable_out(chip_enable_out),
    .mode(chip_mode), .shutter(chip_shutter), .enable_in(chip_enable_in),
    .reset_n(chip_reset_n), .xfer_start(xfer_start), .err_flag(err_flag)
  );
endmodule

// File: tb/test_pixchip_seq.sv
`timescale 1ns/1ps
module test_pixchip_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_shutter = 1'b0;
  logic        chip_enable_out = 1'b0;
  logic [1:0]  chip_mode;
  logic        chip_shutter, chip_enable_in, chip_reset_n, xfer_start, err_flag;

  pixchip_seq i_pixchip_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_shutter(ext_shutter), .chip_enable_out(chip_enable_out),
    .chip_mode(chip_mode), .chip_shutter(chip_shutter), .chip_enable_in(chip_enable_in),
    .chip_reset_n(chip_reset_n), .xfer_start(xfer_start), .err_flag(err_flag)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  localparam int EV_EN_R = 0, EV_XF = 1, EV_EN_F = 2, EV_ERR_R = 3, EV_ERR_F = 4,
                 EV_RN_F = 5, EV_RN_R = 6, EV_SH_R = 7, EV_SH_F = 8;

  typedef struct { int kind; int cyc; int val; string req; } ev_t;
  ev_t exp_q[$];

  task automatic expect_ev(int k, int c, int v, string r);
    ev_t e;
    e.kind = k; e.cyc = c; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic got(int k, int v);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R9 unexpected event: actual kind %0d at cycle %0d, expected none", k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.cyc != cyc || e.val != v) begin
        fails++;
        $display("FAIL %s event: actual kind %0d cyc %0d val %0d expected kind %0d cyc %0d val %0d",
                 e.req, k, cyc, v, e.kind, e.cyc, e.val);
      end
    end
  endtask

  // monitor: turns pin edges into events and compares them with the queue
  logic p_en, p_xf, p_err, p_rn, p_sh;
  always @(negedge clk) begin
    if (mon_on) begin
      if (chip_enable_in && !p_en) got(EV_EN_R, int'(chip_mode));
      if (xfer_start && !p_xf)     got(EV_XF, int'(chip_mode));
      if (!chip_enable_in && p_en) got(EV_EN_F, 0);
      if (err_flag && !p_err)      got(EV_ERR_R, 0);
      if (!err_flag && p_err)      got(EV_ERR_F, 0);
      if (!chip_reset_n && p_rn)   got(EV_RN_F, int'(chip_mode));
      if (chip_reset_n && !p_rn)   got(EV_RN_R, 0);
      if (chip_shutter && !p_sh)   got(EV_SH_R, 0);
      if (!chip_shutter && p_sh)   got(EV_SH_F, 0);
    end
    p_en = chip_enable_in; p_xf = xfer_start; p_err = err_flag;
    p_rn = chip_reset_n;   p_sh = chip_shutter;
  end

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(int a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic issue(logic [2:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain(int n, string req);
    repeat (n) @(negedge clk);
    check(exp_q.size() == 0, req, "pending expected events", exp_q.size(), 0);
  endtask

  task automatic xfer(logic [2:0] op, int d);
    int c0;
    c0 = cyc;
    expect_ev(EV_EN_R, c0 + 4, int'(op), "R2");
    expect_ev(EV_XF,   c0 + 4, int'(op), "R3");
    expect_ev(EV_EN_F, c0 + 5 + d, 0, "R3");
    issue(op);
    wait_to(c0 + 4 + d);
    chip_enable_out = 1'b1;
    @(negedge clk);
    chip_enable_out = 1'b0;
    wait_to(c0 + 8 + d);
  endtask

  task automatic timeout_case(int t);
    int c0, te;
    te = (t == 0) ? 1 : t;
    wr(1, 16'(t));
    c0 = cyc;
    expect_ev(EV_EN_R,  c0 + 4, 3, "R2");
    expect_ev(EV_XF,    c0 + 4, 3, "R3");
    expect_ev(EV_EN_F,  c0 + 4 + te, 0, "R4");
    expect_ev(EV_ERR_R, c0 + 4 + te, 0, "R4");
    issue(3'd3);
    wait_to(c0 + 7 + te);
    issue(3'd1);                 // R5: ignored in error
    drain(8, "R5");
    check(err_flag == 1'b1, "R5", "err_flag held", int'(err_flag), 1);
    c0 = cyc;
    expect_ev(EV_ERR_F, c0 + 1, 0, "R5");
    issue(3'd5);
    drain(3, "R5");
  endtask

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    check(chip_reset_n == 1'b1 && chip_enable_in == 1'b0, "R1", "pins in reset", int'(chip_reset_n), 1);
    rst = 1'b0;
    @(negedge clk);
    check(chip_mode == 2'b00, "R1", "mode", int'(chip_mode), 0);
    check(chip_shutter == 1'b0 && chip_enable_in == 1'b0, "R1", "shutter/enable", int'({chip_shutter, chip_enable_in}), 0);
    check(chip_reset_n == 1'b1, "R1", "reset_n", int'(chip_reset_n), 1);
    check(xfer_start == 1'b0 && err_flag == 1'b0, "R1", "xfer/err", int'({xfer_start, err_flag}), 0);
    mon_on = 1'b1;

    // R10: register bank
    for (int i = 0; i < 16; i++) wr(i, 16'((i * 16'h0F1D) ^ 16'hA55A));
    for (int i = 0; i < 16; i++) begin
      reg_addr = 4'(i);
      @(negedge clk);
      check(reg_rdata == 16'((i * 16'h0F1D) ^ 16'hA55A), "R10", "readback",
            int'(reg_rdata), int'(16'((i * 16'h0F1D) ^ 16'hA55A)));
    end
    wr(0, 16'd3); wr(1, 16'd20); wr(2, 16'd0);

    // R2 R3: transfers with different completion delays
    xfer(3'd1, 2);
    xfer(3'd2, 0);
    xfer(3'd3, 3);

    // R9: enable_out outside a transfer
    chip_enable_out = 1'b1; @(negedge clk); chip_enable_out = 1'b0;
    drain(4, "R9");

    // R4 R5: timeouts, including zero
    timeout_case(5);
    timeout_case(0);
    wr(1, 16'd20);

    // R6: matrix clear, with a command issued while busy (R9)
    c0 = cyc;
    expect_ev(EV_RN_F, c0 + 4, 0, "R6");
    expect_ev(EV_RN_R, c0 + 20, 0, "R6");
    issue(3'd0);
    wait_to(c0 + 8);
    issue(3'd1);
    wait_to(c0 + 24);
    drain(2, "R9");

    // R7: internal shutter length 3, ext_shutter toggled and ignored
    c0 = cyc;
    expect_ev(EV_SH_R, c0 + 2, 0, "R7");
    expect_ev(EV_SH_F, c0 + 5, 0, "R7");
    issue(3'd4);
    wait_to(c0 + 2);
    ext_shutter = 1'b1;
    repeat (2) @(negedge clk);
    ext_shutter = 1'b0;
    wait_to(c0 + 8);
    // R7: length 0 behaves as 1
    wr(0, 16'd0);
    c0 = cyc;
    expect_ev(EV_SH_R, c0 + 2, 0, "R7");
    expect_ev(EV_SH_F, c0 + 3, 0, "R7");
    issue(3'd4);
    drain(5, "R7");

    // R8: external shutter source
    wr(2, 16'd1);
    c0 = cyc;
    expect_ev(EV_SH_R, c0 + 4, 0, "R8");
    expect_ev(EV_SH_F, c0 + 8, 0, "R8");
    issue(3'd4);
    wait_to(c0 + 3);
    ext_shutter = 1'b1;
    wait_to(c0 + 7);
    ext_shutter = 1'b0;
    drain(4, "R8");

    // R9: idle ext_shutter, invalid codes, then a normal transfer
    ext_shutter = 1'b1; repeat (3) @(negedge clk); ext_shutter = 1'b0;
    issue(3'd6);
    issue(3'd7);
    drain(8, "R9");
    xfer(3'd2, 1);
    drain(2, "R3");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule